// File: doc/BRIEF.md
# Shift Queue with In-Place Entry Cancellation

This block is a small in-order queue whose entries move one slot toward the head each time the head leaves. Any entry that is already stored can be cancelled where it sits by a per-slot invalidate vector. A typical use is a stream of per-lane requests, some of which are later absorbed into a merged request and must not be issued on their own. A cancelled entry still takes up its slot until it reaches the head. There it is discarded on its own, without being shown on the output and without waiting for the consumer.

Each slot holds an occupancy flag and a separate liveness flag. The occupancy flags always form a contiguous run starting at the head slot. The liveness flags can have holes. The fill level and the write position are derived from the occupancy run alone. Both ports use a ready/valid handshake. Output valid is formed only from registered state, so there is no combinational path from the invalidate vector to output valid.

Top module: `inval_shift_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: `deq_valid` is 0 and `enq_ready` is 1.
- R2: Live entries leave through the dequeue port in the order they were accepted. `deq_data` is the head slot's data, and `deq_valid` is 1 exactly when the head slot is occupied and live. A transfer takes place when `deq_valid` and `deq_ready` are both 1 at a rising edge.
- R3: The queue holds DEPTH entries (4 by default). `enq_ready` is 0 only when all DEPTH slots are occupied and the head does not leave in that cycle.
- R4: Setting bit k of `inval` in a cycle cancels the occupied entry in slot k. Slot 0 is the head, and slot k holds the (k+1)-th oldest stored entry at the start of that cycle. A cancelled entry is never presented with `deq_valid` high.
- R5: An occupied but cancelled entry at the head is removed at the next rising edge whatever the value of `deq_ready`. Cancelled entries are removed one per cycle.
- R6: When the head is cancelled while `deq_valid` is 1, `deq_valid` stays 1 for the rest of that cycle. At the next edge the head leaves even if `deq_ready` is 0.
- R7: Invalidating a slot that is unoccupied at the start of the cycle has no effect. This includes a slot that an enqueue fills in that same cycle.
- R8: An enqueue and a head removal in the same cycle both take effect. A full queue then stays full and takes the new entry at its tail.
- R9: An entry enqueued directly behind a cancelled tail entry is stored and delivered normally once the cancelled entry has been dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Producer offers an entry |
| enq_data | input | DATA_W | Entry payload |
| enq_ready | output | 1 | Queue can accept an entry this cycle |
| deq_valid | output | 1 | Head entry is live and offered |
| deq_data | output | DATA_W | Head entry payload |
| deq_ready | input | 1 | Consumer takes the head entry |
| inval | input | DEPTH | Per-slot cancel request, bit 0 = head |

## Verification
`deq_valid` and `deq_data` depend only on registered slot state. `enq_ready` also depends on the same-cycle `deq_ready` and `inval[0]`. All three are therefore due within the same cycle as the inputs. An enqueue, a removal or a cancellation becomes visible on the outputs one rising edge after it is applied. The bench drives inputs at the falling edge, samples the outputs 1 ns later against a reference model, and advances that model only after the rising edge. Each result is therefore compared in the cycle it belongs to.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // Per-slot bookkeeping: occupancy and liveness are kept apart
    typedef struct packed {
        logic used;
        logic live;
    } slot_flags_t;

    // Slot movement for one cycle
    typedef enum logic {
        MV_KEEP  = 1'b0,
        MV_SHIFT = 1'b1
    } slot_move_e;

    // Apply a cancel request; an unoccupied slot cannot become live
    function automatic slot_flags_t apply_cancel(slot_flags_t f, logic kill);
        slot_flags_t r;
        r.used = f.used;
        r.live = f.live & f.used & ~kill;
        return r;
    endfunction

    // Flags of a freshly written entry
    function automatic slot_flags_t fresh_entry();
        slot_flags_t r;
        r.used = 1'b1;
        r.live = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] used_vec,
    input  logic             head_live,
    input  logic             deq_ready,
    input  logic             head_kill,
    input  logic             enq_valid,
    output logic             shift,
    output logic             enq_ready,
    output logic [DEPTH-1:0] wr_sel
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] wpos;
    logic             enq_fire;

    always_comb begin
        // head leaves when taken, when already dead, or when killed now
        shift     = used_vec[0] & (deq_ready | ~head_live | head_kill);
        enq_ready = ~used_vec[DEPTH-1] | shift;
        enq_fire  = enq_valid & enq_ready;
        fill      = CNT_W'($countones(used_vec));
        wpos      = fill - CNT_W'(shift);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign wr_sel[g] = enq_fire & (wpos == CNT_W'(g));
    end

endmodule

// File: rtl/sq_slot.sv
module sq_slot
    import sq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              kill_self,
    input  logic              kill_next,
    input  slot_flags_t       nxt_flags,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output slot_flags_t       flags_q,
    output logic [DATA_W-1:0] data_q
);
    slot_move_e        move;
    slot_flags_t       flags_n;
    logic [DATA_W-1:0] data_n;

    always_comb begin
        move = shift ? MV_SHIFT : MV_KEEP;
        unique case (move)
            MV_SHIFT: begin
                flags_n = apply_cancel(nxt_flags, kill_next);
                data_n  = nxt_data;
            end
            default: begin
                flags_n = apply_cancel(flags_q, kill_self);
                data_n  = data_q;
            end
        endcase
        if (wr_en) begin
            flags_n = fresh_entry();
            data_n  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            data_q  <= '0;
        end else begin
            flags_q <= flags_n;
            data_q  <= data_n;
        end
    end

endmodule

// File: rtl/inval_shift_queue.sv
module inval_shift_queue
    import sq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_ready,
    output logic              deq_valid,
    output logic [DATA_W-1:0] deq_data,
    input  logic              deq_ready,
    input  logic [DEPTH-1:0]  inval
);
    slot_flags_t       flg     [DEPTH];
    logic [DATA_W-1:0] dat     [DEPTH];
    slot_flags_t       nbr_flg [DEPTH];
    logic [DATA_W-1:0] nbr_dat [DEPTH];
    logic [DEPTH-1:0]  nbr_kill;
    logic [DEPTH-1:0]  used_q;
    logic [DEPTH-1:0]  live_q;
    logic [DEPTH-1:0]  wr_sel;
    logic              shift;

    sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .used_vec  (used_q),
        .head_live (live_q[0]),
        .deq_ready (deq_ready),
        .head_kill (inval[0]),
        .enq_valid (enq_valid),
        .shift     (shift),
        .enq_ready (enq_ready),
        .wr_sel    (wr_sel)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == DEPTH - 1) begin : g_tail
            assign nbr_flg[g]  = '0;
            assign nbr_dat[g]  = '0;
            assign nbr_kill[g] = 1'b0;
        end else begin : g_body
            assign nbr_flg[g]  = flg[g+1];
            assign nbr_dat[g]  = dat[g+1];
            assign nbr_kill[g] = inval[g+1];
        end

        sq_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .shift     (shift),
            .kill_self (inval[g]),
            .kill_next (nbr_kill[g]),
            .nxt_flags (nbr_flg[g]),
            .nxt_data  (nbr_dat[g]),
            .wr_en     (wr_sel[g]),
            .wr_data   (enq_data),
            .flags_q   (flg[g]),
            .data_q    (dat[g])
        );

        assign used_q[g] = flg[g].used;
        assign live_q[g] = flg[g].live;
    end

    assign deq_valid = used_q[0] & live_q[0];
    assign deq_data  = dat[0];

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              enq_valid,
    input logic              enq_ready,
    input logic              deq_valid,
    input logic [DATA_W-1:0] deq_data,
    input logic              deq_ready,
    input logic [DEPTH-1:0]  inval,
    input logic [DEPTH-1:0]  used_q,
    input logic [DEPTH-1:0]  live_q
);
    // R1
    empty_after_reset_chk: assert property (@(posedge clk)
        rst |=> (!deq_valid && enq_ready));

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !enq_ready |-> (deq_valid && !deq_ready && !inval[0]));

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && !deq_ready && !inval[0]) |=> (deq_valid && $stable(deq_data)));

    // R5
    dead_head_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (used_q[0] && !live_q[0] && !enq_valid)
        |=> ($countones(used_q) == $past($countones(used_q)) - 1));

    // R4
    live_needs_used_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q & ~used_q) == '0);

    // R8
    used_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({1'b0, used_q} + {{DEPTH{1'b0}}, 1'b1}));

endmodule

bind inval_shift_queue sq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .deq_valid (deq_valid),
    .deq_data  (deq_data),
    .deq_ready (deq_ready),
    .inval     (inval),
    .used_q    (used_q),
    .live_q    (live_q)
);

// File: tb/sim_inval_shift_queue.sv
module sim_inval_shift_queue;
    localparam int D  = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [DW-1:0] enq_data = '0;
    logic          enq_ready;
    logic          deq_valid;
    logic [DW-1:0] deq_data;
    logic          deq_ready = 1'b0;
    logic [D-1:0]  inval = '0;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference model
    int            m_cnt = 0;
    logic [DW-1:0] md [D];
    bit            mv [D];

    inval_shift_queue #(.DEPTH(D), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_data(enq_data),
        .enq_ready(enq_ready), .deq_valid(deq_valid), .deq_data(deq_data),
        .deq_ready(deq_ready), .inval(inval)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit exp_shift(bit dr, logic [D-1:0] iv);
        return (m_cnt > 0) && (!mv[0] || iv[0] || dr);
    endfunction

    function automatic bit exp_valid();
        return (m_cnt > 0) && mv[0];
    endfunction

    function automatic bit exp_ready(bit dr, logic [D-1:0] iv);
        return (m_cnt < D) || exp_shift(dr, iv);
    endfunction

    task automatic model_update(bit ev, logic [DW-1:0] ed, bit dr, logic [D-1:0] iv);
        bit sh;
        bit ef;
        sh = exp_shift(dr, iv);
        ef = ev && exp_ready(dr, iv);
        for (int i = 0; i < D; i++) if (i < m_cnt && iv[i]) mv[i] = 0;
        if (sh) begin
            for (int i = 0; i < D - 1; i++) begin
                md[i] = md[i+1];
                mv[i] = mv[i+1];
            end
            mv[D-1] = 0;
            m_cnt--;
        end
        if (ef) begin
            md[m_cnt] = ed;
            mv[m_cnt] = 1;
            m_cnt++;
        end
    endtask

    task automatic step(bit ev, logic [DW-1:0] ed, bit dr, logic [D-1:0] iv, string tag);
        @(negedge clk);
        enq_valid = ev;
        enq_data  = ed;
        deq_ready = dr;
        inval     = iv;
        #1;
        chk(32'(deq_valid), 32'(exp_valid()), {tag, " deq_valid"});
        if (exp_valid()) chk(32'(deq_data), 32'(md[0]), {tag, " deq_data"});
        chk(32'(enq_ready), 32'(exp_ready(dr, iv)), {tag, " enq_ready"});
        @(posedge clk);
        model_update(ev, ed, dr, iv);
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 2 * D + 2; i++) step(0, '0, 1, '0, tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < D; i++) begin md[i] = '0; mv[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(32'(deq_valid), 0, "R1 reset deq_valid");
        chk(32'(enq_ready), 1, "R1 reset enq_ready");
        rst = 0;
        step(0, '0, 0, '0, "R1");

        // fill to capacity, then confirm back-pressure
        for (int i = 0; i < D; i++) step(1, DW'(8'hA0 + i), 0, '0, "R3 fill");
        step(1, 8'hEE, 0, '0, "R3 full");
        chk(32'(m_cnt), D, "R3 model level");
        // simultaneous enqueue and dequeue while full
        step(1, 8'hA4, 1, '0, "R8");
        step(0, '0, 0, '0, "R8 after");
        chk(32'(deq_data), 32'h A1, "R8 head");
        // cancel slot 1 (A2) then drain; A2 must be skipped
        step(0, '0, 0, 4'b0010, "R4");
        drain("R4 drain");

        // head cancel while consumer stalls
        step(1, 8'hB0, 0, '0, "R6 load");
        step(1, 8'hB1, 0, '0, "R6 load");
        step(0, '0, 0, 4'b0001, "R6 same-cycle");
        step(0, '0, 0, '0, "R6 next");
        chk(32'(deq_data), 32'hB1, "R6 new head");
        drain("R6 drain");

        // two dead entries at the head drop without ready
        for (int i = 0; i < 3; i++) step(1, DW'(8'hC0 + i), 0, '0, "R5 load");
        step(0, '0, 0, 4'b0011, "R5 kill");
        step(0, '0, 0, '0, "R5 drop1");
        step(0, '0, 0, '0, "R5 drop2");
        chk(32'(deq_valid), 1, "R5 live head");
        chk(32'(deq_data), 32'hC2, "R5 head data");
        drain("R5 drain");

        // cancel of unused slots, including one being written now
        step(1, 8'hD0, 0, 4'b1100, "R7 write");
        step(1, 8'hD1, 0, 4'b0010, "R7 same-cycle");
        step(0, '0, 0, 4'b1000, "R7 idle");
        chk(32'(m_cnt), 2, "R7 level");
        drain("R7 drain");

        // enqueue right behind a cancelled tail
        step(1, 8'hE0, 0, '0, "R9 load");
        step(1, 8'hE1, 0, '0, "R9 load");
        step(1, 8'hE2, 0, 4'b0010, "R9 kill tail");
        step(0, '0, 0, '0, "R9 hold");
        drain("R9 drain");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [D-1:0] iv;
            iv = ($urandom % 5 == 0) ? D'(1 << ($urandom % D)) : '0;
            step(($urandom % 4) != 0, DW'($urandom), ($urandom % 3) != 0, iv, "R2 random");
        end
        drain("R2 final");
        chk(32'(deq_valid), 0, "R2 empty at end");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule